// File: doc/BRIEF.md
# Quad DAC Serial Register Core

This block is the digital front end of a four-channel, 12-bit voltage-output converter. A host shifts 16-bit words in, most significant bit first. The shift register advances on every rising edge of the OR of the chip-select and serial-clock pins, so either pin can act as the shift clock. The two top bits of the word pick one of four 12-bit code registers. While the active-low load strobe is held low, the picked register follows the code field of the shift register. While the strobe is high, all four registers hold.

An active-low clear input forces all four code registers to zero-scale (0x000) or to mid-scale (0x800). A clear-select pin picks which of the two. The clear has priority over a load, and it leaves the shift register untouched. When the clear is released, every register that is not being loaded keeps the cleared value.

All pins are sampled by a fast system clock through a two-flop synchronizer, and the shift clock is recovered by detecting rising edges. The four codes leave the block as one flat bus that feeds the analog ladders. The shift register is brought out as a debug view.

Top module: `quad_dac_serial_core`

## Requirements
- R1: The word is shifted in MSB first. Bits [15:14] are the channel address and bits [11:0] are the code. Bits [13:12] have no effect on any code. `shift_word_o` shows the 16 bits last shifted, with the first bit sent at bit 15.
- R2: The shift register moves one place, taking `sdi_i` into bit 0, on each rising edge of (`cs_i` OR `sclk_i`). Clocking `sclk_i` with `cs_i` low and clocking `cs_i` with `sclk_i` low give the same result.
- R3: Raising `cs_i` while `sclk_i` is low is a rising edge of the OR and shifts one extra bit.
- R4: While the OR of `cs_i` and `sclk_i` stays high, the shift register does not change, whatever `sdi_i` and the other pin do.
- R5: Address 0 selects channel A (`codes_o[11:0]`), 1 selects B (`[23:12]`), 2 selects C (`[35:24]`) and 3 selects D (`[47:36]`). While `load_ni` is low and `clr_ni` is high, only the selected channel changes, and it takes bits [11:0] of the shift register.
- R6: While `load_ni` and `clr_ni` are both high, all four codes hold, including while words are being shifted.
- R7: While `clr_ni` is low, all four codes are 0x000 if `clr_mid_i` is low, or 0x800 if it is high. This holds even while `load_ni` is low.
- R8: A clear leaves the shift register contents unchanged.
- R9: When `clr_ni` rises, the channels not being loaded keep the cleared value. If `load_ni` is low at that moment, the addressed channel takes the shift-register code.
- R10: If bits are shifted while `load_ni` is low, each intermediate word writes its own code field into the channel that its own bits [15:14] address. This corrupts the channels addressed along the way.
- R11: While `rst_ni` is low, and after it is released, the shift register and all four codes read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to sample all pins |
| rst_ni | input | 1 | Asynchronous active-low system reset |
| cs_i | input | 1 | Chip select; ORed with `sclk_i` to form the shift clock |
| sclk_i | input | 1 | Serial clock; ORed with `cs_i` to form the shift clock |
| sdi_i | input | 1 | Serial data, MSB first |
| load_ni | input | 1 | Active-low load strobe; the addressed channel follows while low |
| clr_ni | input | 1 | Active-low clear of all four codes |
| clr_mid_i | input | 1 | Clear value select: 0 gives 0x000, 1 gives 0x800 |
| codes_o | output | 48 | Four 12-bit codes, channel k at [k*12 +: 12] |
| shift_word_o | output | 16 | Debug view of the serial shift register |

## Verification
A sweep covers all four addresses with several codes each: all-zero, all-one and arithmetic mixes. The unused bits vary across the sweep. Words are sent alternately with the serial clock and with chip select as the shift clock, which separates a wrong decode or a corrupted neighbour from a transport that only works on one pin. Separate patterns cover the following cases:
- toggling one pin while the other is held high, which must not shift;
- chip select rising with the clock low, which must add one extra shift;
- clears to both values with the load strobe high and with it low;
- a whole word shifted with the load strobe low, where the bench follows the address and code bit by bit to predict every corrupted channel.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
  localparam int unsigned WORD_W_DEF = 16;
  localparam int unsigned CODE_W_DEF = 12;
  localparam int unsigned ADDR_W_DEF = 2;
  localparam int unsigned SYNC_STAGES_DEF = 2;

  // Bit positions of the pins inside the synchronizer vector
  localparam int unsigned PIN_CS   = 5;
  localparam int unsigned PIN_SCLK = 4;
  localparam int unsigned PIN_SDI  = 3;
  localparam int unsigned PIN_LOAD = 2;
  localparam int unsigned PIN_CLR  = 1;
  localparam int unsigned PIN_MID  = 0;
  localparam int unsigned PIN_W    = 6;
  // Idle levels: select, clock, load and clear high
  localparam logic [PIN_W-1:0] PIN_IDLE = 6'b110110;
endpackage

// File: rtl/qdac_sync.sv
module qdac_sync #(
  parameter int unsigned WIDTH = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= {STAGES{RST_VAL}};
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/qdac_shift_front.sv
module qdac_shift_front #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              sclk_i,
  input  logic              sdi_i,
  output logic              shift_en_o,
  output logic [WORD_W-1:0] word_o
);
  logic lvl, lvl_q;
  logic [WORD_W-1:0] word_q;

  // Either pin high keeps the combined shift clock high
  assign lvl = cs_i | sclk_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b1;
    else         lvl_q <= lvl;
  end

  assign shift_en_o = lvl & ~lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         word_q <= '0;
    else if (shift_en_o) word_q <= {word_q[WORD_W-2:0], sdi_i};
  end

  assign word_o = word_q;
endmodule

// File: rtl/qdac_code_bank.sv
module qdac_code_bank #(
  parameter int unsigned CODE_W = 12,
  parameter int unsigned ADDR_W = 2,
  localparam int unsigned NUM_CH = 1 << ADDR_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     clr_ni,
  input  logic                     clr_mid_i,
  input  logic                     load_ni,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [CODE_W-1:0]        data_i,
  output logic [NUM_CH*CODE_W-1:0] codes_o
);
  localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(1) << (CODE_W - 1);

  logic [CODE_W-1:0] clr_code;
  assign clr_code = clr_mid_i ? MID_CODE : '0;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic [CODE_W-1:0] code_q;
    logic              hit;

    // Models a latch that is open while load is low, addressed by live shift bits
    assign hit = ~load_ni & (addr_i == ADDR_W'(ch));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      code_q <= '0;
      else if (!clr_ni) code_q <= clr_code;
      else if (hit)     code_q <= data_i;
    end

    assign codes_o[ch*CODE_W +: CODE_W] = code_q;
  end
endmodule

// File: rtl/quad_dac_serial_core.sv
module quad_dac_serial_core
  import qdac_pkg::*;
#(
  parameter int unsigned WORD_W = WORD_W_DEF,
  parameter int unsigned CODE_W = CODE_W_DEF,
  parameter int unsigned ADDR_W = ADDR_W_DEF,
  parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              cs_i,
  input  logic                              sclk_i,
  input  logic                              sdi_i,
  input  logic                              load_ni,
  input  logic                              clr_ni,
  input  logic                              clr_mid_i,
  output logic [(1<<ADDR_W)*CODE_W-1:0]     codes_o,
  output logic [WORD_W-1:0]                 shift_word_o
);
  localparam int unsigned NUM_CH = 1 << ADDR_W;

  logic [PIN_W-1:0] pins_raw, pins_s;
  logic cs_s, sclk_s, sdi_s, load_n_s, clr_n_s, clr_mid_s;
  logic shift_en;
  logic [WORD_W-1:0] shift_word;
  logic [NUM_CH*CODE_W-1:0] codes;

  always_comb begin
    pins_raw = '0;
    pins_raw[PIN_CS]   = cs_i;
    pins_raw[PIN_SCLK] = sclk_i;
    pins_raw[PIN_SDI]  = sdi_i;
    pins_raw[PIN_LOAD] = load_ni;
    pins_raw[PIN_CLR]  = clr_ni;
    pins_raw[PIN_MID]  = clr_mid_i;
  end

  qdac_sync #(
    .WIDTH  (PIN_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL(PIN_IDLE)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pins_raw),
    .q_o   (pins_s)
  );

  assign cs_s      = pins_s[PIN_CS];
  assign sclk_s    = pins_s[PIN_SCLK];
  assign sdi_s     = pins_s[PIN_SDI];
  assign load_n_s  = pins_s[PIN_LOAD];
  assign clr_n_s   = pins_s[PIN_CLR];
  assign clr_mid_s = pins_s[PIN_MID];

  qdac_shift_front #(
    .WORD_W(WORD_W)
  ) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cs_i      (cs_s),
    .sclk_i    (sclk_s),
    .sdi_i     (sdi_s),
    .shift_en_o(shift_en),
    .word_o    (shift_word)
  );

  qdac_code_bank #(
    .CODE_W(CODE_W),
    .ADDR_W(ADDR_W)
  ) u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_ni   (clr_n_s),
    .clr_mid_i(clr_mid_s),
    .load_ni  (load_n_s),
    .addr_i   (shift_word[WORD_W-1 -: ADDR_W]),
    .data_i   (shift_word[CODE_W-1:0]),
    .codes_o  (codes)
  );

  assign codes_o      = codes;
  assign shift_word_o = shift_word;
endmodule

// File: rtl/qdac_checker.sv
module qdac_checker #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned CODE_W = 12,
  parameter int unsigned ADDR_W = 2,
  localparam int unsigned NUM_CH = 1 << ADDR_W
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     shift_en_i,
  input logic                     sdi_i,
  input logic [WORD_W-1:0]        word_i,
  input logic                     clr_ni,
  input logic                     clr_mid_i,
  input logic                     load_ni,
  input logic [NUM_CH*CODE_W-1:0] codes_i
);
  localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(1) << (CODE_W - 1);

  logic [NUM_CH*CODE_W-1:0] codes_d;
  logic [NUM_CH-1:0]        chg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) codes_d <= '0;
    else         codes_d <= codes_i;
  end

  always_comb begin
    for (int c = 0; c < NUM_CH; c++)
      chg[c] = codes_i[c*CODE_W +: CODE_W] != codes_d[c*CODE_W +: CODE_W];
  end

  function automatic logic [CODE_W-1:0] pick(input logic [NUM_CH*CODE_W-1:0] v,
                                             input logic [ADDR_W-1:0] idx);
    return v[idx*CODE_W +: CODE_W];
  endfunction

  // R2: one place per shift pulse, new bit enters at bit 0
  a_r2_shift_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_en_i |=> word_i == {$past(word_i[WORD_W-2:0]), $past(sdi_i)});

  // R4, R8: no pulse, no movement
  a_r4_hold_without_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_en_i |=> $stable(word_i));

  // R5: addressed channel takes the code field
  a_r5_follow_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_ni && !load_ni) |=>
      pick(codes_i, $past(word_i[WORD_W-1 -: ADDR_W])) == $past(word_i[CODE_W-1:0]));

  // R5: at most one channel changes per cycle outside a clear
  a_r5_single_channel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_ni |=> $onehot0(chg));

  // R6: latched registers hold
  a_r6_latched_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_ni && load_ni) |=> $stable(codes_i));

  // R7: clear value on all channels
  a_r7_clear_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_ni |=> codes_i == ($past(clr_mid_i) ? {NUM_CH{MID_CODE}} : '0));
endmodule

bind quad_dac_serial_core qdac_checker #(
  .WORD_W(WORD_W),
  .CODE_W(CODE_W),
  .ADDR_W(ADDR_W)
) u_qdac_checker (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .shift_en_i(shift_en),
  .sdi_i     (sdi_s),
  .word_i    (shift_word),
  .clr_ni    (clr_n_s),
  .clr_mid_i (clr_mid_s),
  .load_ni   (load_n_s),
  .codes_i   (codes)
);

// File: tb/tb_quad_dac_serial_core.sv
module tb_quad_dac_serial_core;
  localparam int WORD_W = 16;
  localparam int CODE_W = 12;
  localparam int ADDR_W = 2;
  localparam int NCH = 4;
  localparam int SETTLE = 6;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cs_i = 1'b1, sclk_i = 1'b1, sdi_i = 1'b0;
  logic load_ni = 1'b1, clr_ni = 1'b1, clr_mid_i = 1'b0;
  logic [NCH*CODE_W-1:0] codes_o;
  logic [WORD_W-1:0] shift_word_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [WORD_W-1:0] m_word = '0;
  logic [CODE_W-1:0] m_code [NCH];
  bit m_load_low = 0;
  bit m_clr_high = 1;

  quad_dac_serial_core #(
    .WORD_W(WORD_W), .CODE_W(CODE_W), .ADDR_W(ADDR_W)
  ) dut (
    .clk_i(clk), .rst_ni(rst_ni), .cs_i(cs_i), .sclk_i(sclk_i), .sdi_i(sdi_i),
    .load_ni(load_ni), .clr_ni(clr_ni), .clr_mid_i(clr_mid_i),
    .codes_o(codes_o), .shift_word_o(shift_word_o)
  );

  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (SETTLE) @(negedge clk);
  endtask

  task automatic follow();
    if (m_load_low && m_clr_high) m_code[m_word[15:14]] = m_word[11:0];
  endtask

  task automatic model_shift(input logic b);
    m_word = {m_word[WORD_W-2:0], b};
    follow();
  endtask

  task automatic check_all(input string tag);
    for (int c = 0; c < NCH; c++) chk(tag, 64'(codes_o[c*CODE_W +: CODE_W]), 64'(m_code[c]));
    chk(tag, 64'(shift_word_o), 64'(m_word));
  endtask

  // Serial clock as shift clock, chip select held low
  task automatic send_sclk(input logic [WORD_W-1:0] w);
    cs_i = 1'b0; settle();
    for (int i = WORD_W - 1; i >= 0; i--) begin
      sclk_i = 1'b0; sdi_i = w[i]; settle();
      sclk_i = 1'b1; settle();
      model_shift(w[i]);
    end
    cs_i = 1'b1; settle();
  endtask

  // Chip select as shift clock, serial clock held low
  task automatic send_cs(input logic [WORD_W-1:0] w);
    sclk_i = 1'b0; settle();
    for (int i = WORD_W - 1; i >= 0; i--) begin
      cs_i = 1'b0; sdi_i = w[i]; settle();
      cs_i = 1'b1; settle();
      model_shift(w[i]);
    end
    sclk_i = 1'b1; settle();
  endtask

  task automatic load_pulse();
    load_ni = 1'b0; m_load_low = 1; follow(); settle();
    load_ni = 1'b1; m_load_low = 0; settle();
  endtask

  task automatic clear_cycle(input logic mid, input string tag);
    clr_mid_i = mid; settle();
    clr_ni = 1'b0; m_clr_high = 0; settle();
    for (int c = 0; c < NCH; c++) m_code[c] = mid ? 12'h800 : 12'h000;
    check_all(tag);
    clr_ni = 1'b1; m_clr_high = 1; follow(); settle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog (all R): got timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < NCH; c++) m_code[c] = '0;
    repeat (3) @(negedge clk);
    check_all("R11 in reset");
    rst_ni = 1'b1; settle();
    check_all("R11 after reset");

    // Sweep: every address, several codes, both shift-clock pins
    for (int a = 0; a < NCH; a++) begin
      for (int k = 0; k < 6; k++) begin
        logic [CODE_W-1:0] d;
        logic [WORD_W-1:0] w;
        d = (k == 0) ? 12'h000 : (k == 1) ? 12'hFFF : 12'((a * 'h3C1 + k * 'h2B7) & 'hFFF);
        w = {2'(a), 2'(k % 4), d};
        if (k % 2 == 0) send_sclk(w); else send_cs(w);
        check_all("R1 R2 R6 word shifted, codes held");
        load_pulse();
        check_all("R5 addressed load");
      end
    end

    // R4: chip select high, serial clock toggles
    for (int i = 0; i < 8; i++) begin
      sdi_i = i[0]; sclk_i = 1'b0; settle();
      sclk_i = 1'b1; settle();
    end
    check_all("R4 no shift with combined clock high");

    // R3: chip select rises while clock is low
    cs_i = 1'b0; settle();
    sclk_i = 1'b0; sdi_i = 1'b1; settle();
    cs_i = 1'b1; settle();
    model_shift(1'b1);
    check_all("R3 extra shift on select rise");
    sclk_i = 1'b1; settle();

    // R7 R8 R9: mid-scale clear with load high
    send_sclk(16'h4ABC);
    clear_cycle(1'b1, "R7 R8 mid clear");
    check_all("R9 latched keep mid after release");

    // R7 R9: zero clear with load low, priority then follow on release
    load_ni = 1'b0; m_load_low = 1; follow(); settle();
    clear_cycle(1'b0, "R7 zero clear over load");
    check_all("R9 selected follows, others zero");
    load_ni = 1'b1; m_load_low = 0; settle();
    check_all("R6 hold after load release");

    // R10: shifting with load low corrupts channels along the way
    clear_cycle(1'b1, "R7 mid clear before ripple");
    load_ni = 1'b0; m_load_low = 1; follow(); settle();
    send_sclk(16'hB6D9);
    check_all("R10 ripple through address bits");
    send_cs(16'h1E35);
    check_all("R10 ripple with select clock");
    load_ni = 1'b1; m_load_low = 0; settle();
    send_sclk(16'hC123);
    check_all("R6 final hold");

    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule